// File: doc/BRIEF.md
# Frame-Linear Display Timing Generator

This block produces horizontal sync, vertical sync and a data-enable strobe for a digital video output, and picks the colour that leaves on the pixel bus. Vertical timing is not counted in lines. A single counter runs across the whole frame in pixel clocks. Vertical sync and the vertical part of the display window are both compared against that frame position, with all bounds expressed in pixel clocks (lines times line period). A line counter restarts every line period and drives hsync and the horizontal part of the window.

Software programs the timing through a small write-only register port. Every write lands in a shadow copy. The active copy reloads from the shadow at the end of each frame, and on every cycle while the generator is stopped. A run bit starts the generator. Clearing that bit stops it only once the current frame has finished, so the next start always begins from a clean frame origin with a fully reloaded configuration. When the pixel source cannot supply data inside the display window, a programmable 8-bit fill value is put on every colour channel. Outside the window, the border colour is driven.

Top module: `fl_timing_gen`

## Requirements
- R1: Synchronous active-low reset clears every shadow and active register and stops the generator: hsync_o, vsync_o and de_o are 0 and pix_o is 0.
- R2: Each register write is one cycle of cfg_we with a word address. The addresses are: 0 run (bit 0); 1 line timing (period in [15:0], sync width in [31:16]); 2 frame length; 3 vsync length; 4 horizontal window (first in [15:0], last in [31:16]); 5 vertical window first; 6 vertical window last; 7 skew; 8 polarity (bit 0 hsync active-low, bit 1 vsync active-low); 9 border colour [23:0]; 10 underflow (fill value [7:0], recovery enable bit 31). While the generator is stopped, the active set follows the shadow set on every cycle.
- R3: While running, the frame position counts from 0 to frame length − 1 and wraps. The line position restarts every line period. Internal hsync is active while the line position is below the sync width. With skew 0, the line position is 0 at frame position 0. With skew S, the line position starts at period − S, so the first hsync begins at frame position S.
- R4: Internal vsync is active while the frame position is below the vsync length.
- R5: de_o is high exactly when the line position lies in the horizontal window and the frame position lies in the vertical window. Both windows include their first and last values.
- R6: hsync_o and vsync_o equal the internal sync XOR the matching polarity bit.
- R7: pix_o carries the border colour when de_o is low. It carries pix_data when de_o is high and pix_valid is high, unless R8 applies.
- R8: When de_o is high and pix_valid is low, pix_o carries the fill value repeated on all three 8-bit channels. If recovery is enabled, data resumes on the next cycle with pix_valid high. If recovery is disabled, fill holds for the rest of that frame's window cycles.
- R9: A run bit written as 1 while stopped starts frame position 0 on the second clock edge after the write. A run bit cleared while running takes effect at the next frame wrap. While stopped, de_o is 0 and each sync output rests at its polarity bit.
- R10: Register writes made mid-frame do not change the outputs until the frame after the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | DATA_W | Register write data |
| pix_valid | input | 1 | Pixel source has a pixel this cycle |
| pix_data | input | 24 | Pixel from the source |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data-enable / pixel-valid strobe |
| pix_o | output | 24 | Output colour |

## Verification
A wrong frame or line counter shows up at once: the sync and data-enable edges land at the wrong frame positions, and the window bounds at both ends are sampled to catch this. A shadow or run latch that updates at the wrong moment shows as a polarity or stop that takes effect inside the current frame instead of at the wrap. This is observed within one frame of the write. A wrong underflow flag shows as fill colour that is either released or kept on the cycle after the source recovers, depending on the recovery bit.

// File: rtl/fl_timing_pkg.sv
// Shared widths, register addresses and the timing configuration record.
package fl_timing_pkg;
    parameter int H_W   = 16;          // line-position field width
    parameter int F_W   = 24;          // frame-position field width
    parameter int CH_W  = 8;           // bits per colour channel
    parameter int N_CH  = 3;           // colour channels per pixel
    localparam int PIX_W = CH_W * N_CH;

    // register word addresses
    localparam int ADR_RUN    = 0;
    localparam int ADR_HTIME  = 1;
    localparam int ADR_FLEN   = 2;
    localparam int ADR_VPULSE = 3;
    localparam int ADR_HWIN   = 4;
    localparam int ADR_VLO    = 5;
    localparam int ADR_VHI    = 6;
    localparam int ADR_SKEW   = 7;
    localparam int ADR_POL    = 8;
    localparam int ADR_BORDER = 9;
    localparam int ADR_UFLOW  = 10;

    typedef struct packed {
        logic [H_W-1:0]   h_period;
        logic [H_W-1:0]   h_pulse;
        logic [H_W-1:0]   h_win_lo;
        logic [H_W-1:0]   h_win_hi;
        logic [H_W-1:0]   skew;
        logic [F_W-1:0]   f_len;
        logic [F_W-1:0]   v_pulse;
        logic [F_W-1:0]   v_win_lo;
        logic [F_W-1:0]   v_win_hi;
        logic             hs_low;
        logic             vs_low;
        logic [PIX_W-1:0] border;
        logic             uf_recover;
        logic [CH_W-1:0]  uf_fill;
    } fl_cfg_t;
endpackage

// File: rtl/fl_cfg_regs.sv
// Register write decoder holding the shadow configuration and the run request.
// Assumes DATA_W >= 32 and that each field fits its slot in the data word.
module fl_cfg_regs
    import fl_timing_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output fl_cfg_t           shadow_o,
    output logic              run_req_o
);
    localparam int HALF = DATA_W / 2;

    fl_cfg_t shadow_q;
    logic    run_req_q;

    // capture one field group per write into the shadow set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q  <= '0;
            run_req_q <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_W'(ADR_RUN):    run_req_q <= wr_data[0];
                ADDR_W'(ADR_HTIME): begin
                    shadow_q.h_period <= wr_data[H_W-1:0];
                    shadow_q.h_pulse  <= wr_data[HALF +: H_W];
                end
                ADDR_W'(ADR_FLEN):   shadow_q.f_len   <= wr_data[F_W-1:0];
                ADDR_W'(ADR_VPULSE): shadow_q.v_pulse <= wr_data[F_W-1:0];
                ADDR_W'(ADR_HWIN): begin
                    shadow_q.h_win_lo <= wr_data[H_W-1:0];
                    shadow_q.h_win_hi <= wr_data[HALF +: H_W];
                end
                ADDR_W'(ADR_VLO):    shadow_q.v_win_lo <= wr_data[F_W-1:0];
                ADDR_W'(ADR_VHI):    shadow_q.v_win_hi <= wr_data[F_W-1:0];
                ADDR_W'(ADR_SKEW):   shadow_q.skew     <= wr_data[H_W-1:0];
                ADDR_W'(ADR_POL): begin
                    shadow_q.hs_low <= wr_data[0];
                    shadow_q.vs_low <= wr_data[1];
                end
                ADDR_W'(ADR_BORDER): shadow_q.border <= wr_data[PIX_W-1:0];
                ADDR_W'(ADR_UFLOW): begin
                    shadow_q.uf_fill    <= wr_data[CH_W-1:0];
                    shadow_q.uf_recover <= wr_data[DATA_W-1];
                end
                default: ;
            endcase
        end
    end

    assign shadow_o  = shadow_q;
    assign run_req_o = run_req_q;
endmodule

// File: rtl/fl_frame_timer.sv
// Frame-wide position counter, line counter and raw sync generation.
// The active configuration reloads from the shadow at each frame wrap and on
// every cycle while stopped. Assumes skew < line period and frame length > 0.
module fl_frame_timer
    import fl_timing_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  fl_cfg_t        shadow_i,
    input  logic           run_req_i,
    output fl_cfg_t        act_o,
    output logic           running_o,
    output logic           reload_o,
    output logic [H_W-1:0] h_pos_o,
    output logic [F_W-1:0] f_pos_o,
    output logic           hs_o,
    output logic           vs_o
);
    fl_cfg_t        act_q;
    logic           running_q;
    logic [H_W-1:0] h_pos_q;
    logic [F_W-1:0] f_pos_q;
    logic           wrap;
    logic           reload;
    logic [H_W-1:0] h_start;

    assign wrap    = running_q && (f_pos_q == act_q.f_len - F_W'(1));
    assign reload  = !running_q || wrap;
    assign h_start = (shadow_i.skew == '0) ? '0 : shadow_i.h_period - shadow_i.skew;

    // advance positions, or reload configuration and run state at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= '0;
            running_q <= 1'b0;
            h_pos_q   <= '0;
            f_pos_q   <= '0;
        end else if (reload) begin
            act_q     <= shadow_i;
            running_q <= run_req_i;
            h_pos_q   <= h_start;
            f_pos_q   <= '0;
        end else begin
            f_pos_q <= f_pos_q + F_W'(1);
            h_pos_q <= (h_pos_q == act_q.h_period - H_W'(1)) ? '0 : h_pos_q + H_W'(1);
        end
    end

    assign hs_o      = running_q && (h_pos_q < act_q.h_pulse);
    assign vs_o      = running_q && (f_pos_q < act_q.v_pulse);
    assign act_o     = act_q;
    assign running_o = running_q;
    assign reload_o  = reload;
    assign h_pos_o   = h_pos_q;
    assign f_pos_o   = f_pos_q;

    // R3: frame position never reaches the programmed length
    assert_fpos_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && act_q.f_len != '0) |-> (f_pos_q < act_q.f_len));
    // R3: line position stays below the line period
    assert_hpos_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && act_q.skew < act_q.h_period) |-> (h_pos_q < act_q.h_period));
    // R3: a start always begins at the frame origin
    assert_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_q) |-> (f_pos_q == '0));
    // R10: active configuration is frozen inside a frame
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !wrap) |=> $stable(act_q));
endmodule

// File: rtl/fl_video_out.sv
// Window comparison, polarity, and output colour selection with underflow fill.
// Assumes the timer supplies positions and the active configuration for the same cycle.
module fl_video_out
    import fl_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  fl_cfg_t          act_i,
    input  logic             running_i,
    input  logic             reload_i,
    input  logic [H_W-1:0]   h_pos_i,
    input  logic [F_W-1:0]   f_pos_i,
    input  logic             hs_i,
    input  logic             vs_i,
    input  logic             pix_valid_i,
    input  logic [PIX_W-1:0] pix_data_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [PIX_W-1:0] pix_o
);
    logic             h_in;
    logic             v_in;
    logic             de;
    logic             starve;
    logic             uf_q;
    logic [PIX_W-1:0] fill;

    assign h_in = (h_pos_i >= act_i.h_win_lo) && (h_pos_i <= act_i.h_win_hi);
    assign v_in = (f_pos_i >= act_i.v_win_lo) && (f_pos_i <= act_i.v_win_hi);
    assign de   = running_i && h_in && v_in;

    for (genvar c = 0; c < N_CH; c++) begin : g_fill
        assign fill[c*CH_W +: CH_W] = act_i.uf_fill;
    end

    // remember an underflow until the frame ends
    always_ff @(posedge clk) begin
        if (!rst_n)
            uf_q <= 1'b0;
        else if (reload_i)
            uf_q <= 1'b0;
        else if (de && !pix_valid_i)
            uf_q <= 1'b1;
    end

    assign starve  = !pix_valid_i || (uf_q && !act_i.uf_recover);
    assign pix_o   = !de ? act_i.border : (starve ? fill : pix_data_i);
    assign de_o    = de;
    assign hsync_o = hs_i ^ act_i.hs_low;
    assign vsync_o = vs_i ^ act_i.vs_low;

    // R9: stopped generator rests at polarity levels with no data-enable
    assert_idle_levels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !running_i |-> (hsync_o == act_i.hs_low && vsync_o == act_i.vs_low && !de_o));
    // R8: without recovery, a flagged underflow keeps fill on window cycles
    assert_hold_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_q && !act_i.uf_recover && de_o) |-> (pix_o == fill));
    // R7: outside the window the border colour is driven
    assert_border_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !de_o |-> (pix_o == act_i.border));
endmodule

// File: rtl/fl_timing_gen.sv
// Top level: register shadow, frame timer and video output stage.
// Outputs are decoded from registered counters, with no added latency.
module fl_timing_gen
    import fl_timing_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [PIX_W-1:0]  pix_o
);
    fl_cfg_t        shadow;
    fl_cfg_t        act;
    logic           run_req;
    logic           running;
    logic           reload;
    logic [H_W-1:0] h_pos;
    logic [F_W-1:0] f_pos;
    logic           hs;
    logic           vs;

    fl_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .shadow_o (shadow),
        .run_req_o(run_req)
    );

    fl_frame_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .shadow_i (shadow),
        .run_req_i(run_req),
        .act_o    (act),
        .running_o(running),
        .reload_o (reload),
        .h_pos_o  (h_pos),
        .f_pos_o  (f_pos),
        .hs_o     (hs),
        .vs_o     (vs)
    );

    fl_video_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (act),
        .running_i  (running),
        .reload_i   (reload),
        .h_pos_i    (h_pos),
        .f_pos_i    (f_pos),
        .hs_i       (hs),
        .vs_i       (vs),
        .pix_valid_i(pix_valid),
        .pix_data_i (pix_data),
        .hsync_o    (hsync_o),
        .vsync_o    (vsync_o),
        .de_o       (de_o),
        .pix_o      (pix_o)
    );
endmodule

// File: tb/fl_timing_gen_bench.sv
`timescale 1ns/1ps
module fl_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        pix_valid;
    logic [23:0] pix_data;
    logic        hsync_o, vsync_o, de_o;
    logic [23:0] pix_o;

    int checks   = 0;
    int failures = 0;
    int cur      = 0;

    localparam logic [23:0] DATA   = 24'hA5B6C7;
    localparam logic [23:0] BORDER = 24'h102030;

    // frame position and expected {hsync, vsync, de} for frame 1
    localparam int NROW = 17;
    localparam int ROW_POS [NROW] = '{0, 1, 2, 9, 10, 14, 19, 20, 24, 28, 29, 34, 44, 48, 54, 59, 60};
    localparam logic [2:0] ROW_EXP [NROW] = '{3'b110, 3'b110, 3'b010, 3'b010, 3'b100, 3'b000,
        3'b000, 3'b100, 3'b001, 3'b001, 3'b000, 3'b001, 3'b001, 3'b000, 3'b000, 3'b000, 3'b110};

    fl_timing_gen u_fl_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_o(pix_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        cur++;
    endtask

    task automatic goto_pos(input int p);
        repeat (p - cur) @(negedge clk);
        cur = p;
    endtask

    initial begin
        #(20 * 200000);
        failures++; checks++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        pix_valid = 1'b1; pix_data = DATA;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 hsync", hsync_o, 0);
        check("R1 vsync", vsync_o, 0);
        check("R1 de", de_o, 0);
        check("R1 pix", pix_o, 0);

        // R2 program a 10-clock line, 6-line frame
        wr(1, 32'h0002_000A);
        wr(2, 60);
        wr(3, 10);
        wr(4, 32'h0008_0004);
        wr(5, 20);
        wr(6, 44);
        wr(9, {8'h0, BORDER});
        wr(1 - 1, 1);
        cur = -1;

        // table walk over frame 1 (R3, R4, R5, R7)
        for (int i = 0; i < NROW; i++) begin
            goto_pos(ROW_POS[i]);
            check($sformatf("R3 hsync pos %0d", ROW_POS[i]), hsync_o, ROW_EXP[i][2]);
            check($sformatf("R4 vsync pos %0d", ROW_POS[i]), vsync_o, ROW_EXP[i][1]);
            check($sformatf("R5 de pos %0d", ROW_POS[i]), de_o, ROW_EXP[i][0]);
            check($sformatf("R7 pix pos %0d", ROW_POS[i]), pix_o, ROW_EXP[i][0] ? DATA : BORDER);
        end

        // R10: polarity and underflow written mid-frame wait for the wrap
        wr(8, 3);
        wr(10, 32'h8000_00FF);
        goto_pos(65);
        check("R10 hsync unchanged", hsync_o, 0);
        check("R10 vsync unchanged", vsync_o, 1);
        // R6 active-low syncs in the next frame
        goto_pos(120);
        check("R6 hsync low-active", hsync_o, 0);
        check("R6 vsync low-active", vsync_o, 0);
        goto_pos(122);
        check("R6 hsync idle high", hsync_o, 1);
        check("R6 vsync still active", vsync_o, 0);

        // R8 underflow with recovery
        goto_pos(144);
        pix_valid = 1'b0; #1;
        check("R8 fill", pix_o, 24'hFFFFFF);
        goto_pos(145);
        pix_valid = 1'b1; #1;
        check("R8 recovered", pix_o, DATA);
        wr(10, 32'h0000_003C);

        // R8 underflow without recovery holds fill for the frame
        goto_pos(204);
        pix_valid = 1'b0; #1;
        check("R8 fill no-recover", pix_o, 24'h3C3C3C);
        goto_pos(205);
        pix_valid = 1'b1; #1;
        check("R8 hold fill", pix_o, 24'h3C3C3C);
        goto_pos(209);
        check("R8 border outside", pix_o, BORDER);
        goto_pos(214);
        check("R8 hold fill later line", pix_o, 24'h3C3C3C);
        goto_pos(264);
        check("R8 cleared next frame", pix_o, DATA);

        // R9 stop latches at the wrap
        wr(0, 0);
        goto_pos(284);
        check("R9 still running", de_o, 1);
        goto_pos(300);
        check("R9 idle hsync", hsync_o, 1);
        check("R9 idle vsync", vsync_o, 1);
        check("R9 idle de", de_o, 0);
        check("R9 idle pix", pix_o, BORDER);
        goto_pos(310);
        check("R9 stays idle", de_o, 0);

        // R2 idle writes reach the active set; R3 skew of 3
        wr(7, 3);
        wr(8, 0);
        wr(0, 1);
        cur = -1;
        goto_pos(0);
        check("R2 skew applied hsync", hsync_o, 0);
        check("R9 restart vsync", vsync_o, 1);
        goto_pos(2);
        check("R3 skew before edge", hsync_o, 0);
        goto_pos(3);
        check("R3 skew edge", hsync_o, 1);
        goto_pos(5);
        check("R3 skew pulse end", hsync_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule